// File: doc/BRIEF.md
# Fully Associative Victim Buffer

This block is a small, fully associative store of whole cache blocks that sits between a direct-mapped first-level cache and the next memory level. When the first-level cache throws a line out, the line is pushed here together with its dirty state. When the first-level cache misses, it looks the block up here. Because every entry may hold any block, two blocks that collide in one direct-mapped line can both stay close to the processor. Conflict misses drop, and the first-level hit path gains no extra delay.

An address is split into a block tag (every bit above the byte offset) and a byte offset; there is no index field. A lookup compares the tag against every valid entry in the same cycle. The result comes back on the following cycle. On a hit the block goes back to the first-level cache and leaves the buffer. A push issued in the same cycle normally lands in the entry that was just freed, so the two caches swap lines. A lookup miss means the request must go to the next level. When a push finds the buffer full, an entry chosen by a round-robin pointer makes room. If that entry is dirty, it leaves through a write-back port.

Top module: `victim_cache`

## Requirements
- R1: The block tag is address bits [ADDR_W-1:OFS_W] (bits [23:2] by default). The byte-offset bits [OFS_W-1:0] take no part in matching, so a lookup with any offset hits a block pushed with another offset.
- R2: `res_valid` is high in exactly the cycle after a cycle with `look_valid` high, and low after a cycle with `look_valid` low.
- R3: A lookup hits only when a valid entry holds its tag. On a hit, `res_hit` is 1 and `res_data`/`res_dirty` carry that entry's block and dirty flag. On a miss, `res_hit`, `res_data` and `res_dirty` are all zero.
- R4: A lookup hit with no push in the same cycle invalidates the hit entry, so an immediate second lookup of that tag misses.
- R5: A lookup hit with a push of a new tag in the same cycle swaps the lines. The pushed line takes the hit entry, no write-back is raised, the pushed tag then hits, and the returned tag then misses.
- R6: A push of a new tag while some entry is invalid fills the invalid entry with the lowest index and raises no write-back.
- R7: A push of a new tag into a full buffer, with no lookup hit in that cycle, replaces the entry at a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping at ENTRIES-1) after each such replacement, and holds otherwise.
- R8: When a replaced entry is dirty, `wb_valid` is high for one cycle, one cycle after the push. `wb_addr` is that entry's tag with a zero offset, and `wb_data` is its block. A clean replaced entry raises no write-back.
- R9: After reset, no entry is valid, every lookup misses, and `res_valid` and `wb_valid` are low.
- R10: A push whose tag is already held overwrites that entry's block and ORs its dirty flag with `push_dirty`. It raises no write-back, and no tag is ever held by two entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A line evicted from the first-level cache is offered |
| push_addr | input | ADDR_W | Address of the evicted line |
| push_data | input | BLK_W | Block contents of the evicted line |
| push_dirty | input | 1 | Evicted line was modified |
| look_valid | input | 1 | First-level miss lookup request |
| look_addr | input | ADDR_W | Lookup address |
| res_valid | output | 1 | Lookup result present (one cycle after request) |
| res_hit | output | 1 | Lookup found the block |
| res_data | output | BLK_W | Returned block, zero on miss |
| res_dirty | output | 1 | Returned block is dirty, zero on miss |
| wb_valid | output | 1 | Dirty block leaving toward the next level |
| wb_addr | output | ADDR_W | Block address of the write-back, offset zero |
| wb_data | output | BLK_W | Block contents of the write-back |

## Verification
A stale valid bit appears as a second hit on a tag that was already handed back, on the very next lookup of that tag. A wrong free-slot choice or a wrong pointer step shows up as the wrong tag missing or surviving, or as a spurious or absent write-back. That becomes visible one cycle after the push that triggers it, or at the next lookup of the displaced tag. A lost or duplicated dirty flag shows up either in `res_dirty` when the block is returned or in the presence of `wb_valid` when the block is displaced. The tests therefore fill the buffer and run swap, merge and round-robin sequences, checking every lookup result and every write-back slot against expectations worked out by hand.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // how the entry written by a push was chosen, in priority order
  typedef enum logic [1:0] {
    SLOT_MERGE = 2'd0,  // pushed tag already resident
    SLOT_SWAP  = 2'd1,  // entry freed by a same-cycle lookup hit
    SLOT_FREE  = 2'd2,  // lowest invalid entry
    SLOT_EVICT = 2'd3   // round-robin victim of a full buffer
  } slot_kind_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 22,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            en,
  input  logic [TAG_W-1:0]                key,
  input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
  input  logic [ENTRIES-1:0]              valid,
  output logic [ENTRIES-1:0]              hit_vec,
  output logic                            hit,
  output logic [IDX_W-1:0]                hit_idx
);
  function automatic logic [IDX_W-1:0] onehot_to_idx(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (v[i]) r = r | IDX_W'(i);
    return r;
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = en & valid[i] & (tags[i] == key);
  end

  assign hit     = |hit_vec;
  assign hit_idx = onehot_to_idx(hit_vec);
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic               push_hit,
  input  logic [IDX_W-1:0]   push_idx,
  input  logic               look_hit,
  input  logic [IDX_W-1:0]   look_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   slot_idx,
  output slot_kind_e         kind,
  output logic               evict,
  output logic [IDX_W-1:0]   rr
);
  function automatic logic [IDX_W-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  logic               any_free;
  logic [IDX_W-1:0]   rr_q;

  assign any_free = ~&valid;

  always_comb begin
    if (push_hit) begin
      kind = SLOT_MERGE;  slot_idx = push_idx;
    end else if (look_hit) begin
      kind = SLOT_SWAP;   slot_idx = look_idx;
    end else if (any_free) begin
      kind = SLOT_FREE;   slot_idx = lowest_free(valid);
    end else begin
      kind = SLOT_EVICT;  slot_idx = rr_q;
    end
  end

  assign evict = push_valid && (kind == SLOT_EVICT);
  assign rr    = rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     rr_q <= '0;
    else if (evict) rr_q <= rr_next(rr_q);
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int OFS_W   = 2,
  parameter int BLK_W   = 32,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [BLK_W-1:0]  push_data,
  input  logic              push_dirty,
  input  logic              look_valid,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [BLK_W-1:0]  res_data,
  output logic              res_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [BLK_W-1:0]  wb_data
);
  function automatic logic [TAG_W-1:0] blk_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [ADDR_W-1:0] blk_addr(input logic [TAG_W-1:0] t);
    return {t, {OFS_W{1'b0}}};
  endfunction

  // entry storage
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][BLK_W-1:0] data_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            dirty_q;

  // named internal events (observed by the checker)
  logic [ENTRIES-1:0] look_hit_vec, push_hit_vec;
  logic               look_hit, push_hit;
  logic [IDX_W-1:0]   look_idx, push_idx, slot_idx, rr;
  slot_kind_e         kind;
  logic               evict;
  logic               evict_dirty;

  vc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_look_match (
    .en(look_valid), .key(blk_tag(look_addr)), .tags(tag_q), .valid(valid_q),
    .hit_vec(look_hit_vec), .hit(look_hit), .hit_idx(look_idx)
  );

  vc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_push_match (
    .en(push_valid), .key(blk_tag(push_addr)), .tags(tag_q), .valid(valid_q),
    .hit_vec(push_hit_vec), .hit(push_hit), .hit_idx(push_idx)
  );

  vc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .push_hit(push_hit), .push_idx(push_idx),
    .look_hit(look_hit), .look_idx(look_idx), .valid(valid_q),
    .slot_idx(slot_idx), .kind(kind), .evict(evict), .rr(rr)
  );

  assign evict_dirty = evict & valid_q[slot_idx] & dirty_q[slot_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q     <= '0;
      data_q    <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_data  <= '0;
      res_dirty <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
    end else begin
      res_valid <= look_valid;
      res_hit   <= look_hit;
      res_data  <= look_hit ? data_q[look_idx] : '0;
      res_dirty <= look_hit & dirty_q[look_idx];
      // returned block leaves the buffer; a push into the same slot wins below
      if (look_hit) valid_q[look_idx] <= 1'b0;
      wb_valid <= evict_dirty;
      if (evict_dirty) begin
        wb_addr <= blk_addr(tag_q[slot_idx]);
        wb_data <= data_q[slot_idx];
      end
      if (push_valid) begin
        tag_q[slot_idx]   <= blk_tag(push_addr);
        data_q[slot_idx]  <= push_data;
        valid_q[slot_idx] <= 1'b1;
        dirty_q[slot_idx] <= push_dirty | ((kind == SLOT_MERGE) & dirty_q[slot_idx]);
      end
    end
  end
endmodule

// File: rtl/victim_cache_checker.sv
module victim_cache_checker #(
  parameter int ENTRIES = 8,
  parameter int BLK_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               look_valid,
  input logic               push_valid,
  input logic               res_valid,
  input logic               res_hit,
  input logic [BLK_W-1:0]   res_data,
  input logic               res_dirty,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] look_hit_vec,
  input logic [ENTRIES-1:0] push_hit_vec,
  input logic               look_hit,
  input logic               push_hit,
  input logic [IDX_W-1:0]   look_idx,
  input logic               evict,
  input logic [IDX_W-1:0]   rr
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |=> res_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !look_valid |=> !res_valid);
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_data == '0 && !res_dirty));
  assert_hit_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && !push_valid) |=> !valid_q[$past(look_idx)]);
  assert_swap_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && push_valid && !push_hit) |=> !wb_valid);
  assert_free_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !(&valid_q)) |=> !wb_valid);
  assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> (rr == (($past(rr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr) + 1'b1)));
  assert_rr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !evict |=> $stable(rr));
  assert_wb_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(evict));
  assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!res_valid && !wb_valid && valid_q == '0));
  assert_unique_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hit_vec) && $onehot0(push_hit_vec));
endmodule

bind victim_cache victim_cache_checker #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .look_valid(look_valid), .push_valid(push_valid),
  .res_valid(res_valid), .res_hit(res_hit), .res_data(res_data), .res_dirty(res_dirty),
  .wb_valid(wb_valid), .valid_q(valid_q), .look_hit_vec(look_hit_vec),
  .push_hit_vec(push_hit_vec), .look_hit(look_hit), .push_hit(push_hit),
  .look_idx(look_idx), .evict(evict), .rr(rr)
);

// File: tb/victim_cache_bench.sv
module victim_cache_bench;
  localparam int AW = 24;
  localparam int BW = 32;
  localparam int TW = 22;

  typedef struct {
    bit            hit;
    logic [BW-1:0] data;
    bit            dirty;
    logic [AW-1:0] addr;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0, push_dirty = 1'b0, look_valid = 1'b0;
  logic [AW-1:0] push_addr = '0, look_addr = '0;
  logic [BW-1:0] push_data = '0;
  logic          res_valid, res_hit, res_dirty, wb_valid;
  logic [BW-1:0] res_data, wb_data;
  logic [AW-1:0] wb_addr;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t rq[$];
  exp_t wq[$];

  always #5 clk = ~clk;

  victim_cache u_victim_cache (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data), .push_dirty(push_dirty),
    .look_valid(look_valid), .look_addr(look_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_data(res_data), .res_dirty(res_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [BW-1:0] blk(input logic [TW-1:0] t);
    return 32'h5A00_0000 ^ {10'd0, t};
  endfunction

  // one cycle of stimulus; expectations queued for the monitor
  task automatic op(input bit pv, input logic [TW-1:0] pt, input logic [BW-1:0] pd, input bit pdy,
                    input bit lv, input logic [TW-1:0] lt, input logic [1:0] lo,
                    input bit eh, input logic [BW-1:0] ed, input bit edy,
                    input bit ew, input logic [TW-1:0] ewt, input string req);
    exp_t e;
    push_valid = pv;  push_addr = {pt, 2'b01};  push_data = pd;  push_dirty = pdy;
    look_valid = lv;  look_addr = {lt, lo};
    if (lv) begin
      e.hit = eh;  e.data = eh ? ed : '0;  e.dirty = eh & edy;  e.addr = '0;  e.req = req;
      rq.push_back(e);
    end
    if (ew) begin
      e.hit = 1'b1;  e.data = blk(ewt);  e.dirty = 1'b1;  e.addr = {ewt, 2'b00};  e.req = req;
      wq.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic push(input logic [TW-1:0] t, input logic [BW-1:0] d, input bit dy, input string req);
    op(1, t, d, dy, 0, '0, 2'd0, 0, '0, 0, 0, '0, req);
  endtask

  task automatic push_wb(input logic [TW-1:0] t, input bit dy, input logic [TW-1:0] wt, input string req);
    op(1, t, blk(t), dy, 0, '0, 2'd0, 0, '0, 0, 1, wt, req);
  endtask

  task automatic look(input logic [TW-1:0] t, input logic [1:0] o, input bit eh,
                      input logic [BW-1:0] ed, input bit edy, input string req);
    op(0, '0, '0, 0, 1, t, o, eh, ed, edy, 0, '0, req);
  endtask

  task automatic idle();
    op(0, '0, '0, 0, 0, '0, 2'd0, 0, '0, 0, 0, '0, "idle");
  endtask

  // monitor: compares outputs shortly after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        checks++;
        if (res_valid != (rq.size() > 0)) begin
          fails++;
          $display("FAIL R2 result timing: res_valid=%0b expected=%0b", res_valid, rq.size() > 0);
          if (rq.size() > 0) void'(rq.pop_front());
        end else if (res_valid) begin
          e = rq.pop_front();
          if (res_hit !== e.hit || res_data !== e.data || res_dirty !== e.dirty) begin
            fails++;
            $display("FAIL %s lookup: hit=%0b data=%h dirty=%0b expected hit=%0b data=%h dirty=%0b",
                     e.req, res_hit, res_data, res_dirty, e.hit, e.data, e.dirty);
          end
        end
        checks++;
        if (wb_valid != (wq.size() > 0)) begin
          fails++;
          $display("FAIL R8 write-back presence: wb_valid=%0b expected=%0b", wb_valid, wq.size() > 0);
          if (wq.size() > 0) void'(wq.pop_front());
        end else if (wb_valid) begin
          e = wq.pop_front();
          if (wb_addr !== e.addr || wb_data !== e.data) begin
            fails++;
            $display("FAIL %s write-back: addr=%h data=%h expected addr=%h data=%h",
                     e.req, wb_addr, wb_data, e.addr, e.data);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs low while in reset
    checks++;
    if (res_valid !== 1'b0 || wb_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outputs: res_valid=%0b wb_valid=%0b expected 0 0", res_valid, wb_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    look(22'h000005, 2'd0, 0, '0, 0, "R9");                       // empty after reset
    // R6: fill lowest free entries, no write-back
    push(22'h000100, blk(22'h000100), 0, "R6");
    push(22'h000101, blk(22'h000101), 0, "R6");
    push(22'h000102, blk(22'h000102), 0, "R6");
    push(22'h000103, blk(22'h000103), 0, "R6");
    // R1/R3: offset ignored, hit returns block; R4: entry removed
    look(22'h000101, 2'd3, 1, blk(22'h000101), 0, "R1");
    look(22'h000101, 2'd0, 0, '0, 0, "R4");
    look(22'h000777, 2'd2, 0, '0, 0, "R3");
    // R5: swap dirty line with a new push
    push(22'h000200, blk(22'h000200), 1, "R6");
    op(1, 22'h000300, blk(22'h000300), 0, 1, 22'h000200, 2'd1,
       1, blk(22'h000200), 1, 0, '0, "R5");
    look(22'h000300, 2'd0, 1, blk(22'h000300), 0, "R5");
    look(22'h000200, 2'd0, 0, '0, 0, "R5");
    // R10: merge into resident tags
    push(22'h000102, 32'hDEAD_0102, 1, "R10");
    look(22'h000102, 2'd0, 1, 32'hDEAD_0102, 1, "R10");
    push(22'h000103, 32'h1111_0103, 1, "R10");
    push(22'h000103, 32'h2222_0103, 0, "R10");
    look(22'h000103, 2'd2, 1, 32'h2222_0103, 1, "R10");
    // only entry 0 (tag 100) remains; fill entries 1..7, odd k dirty
    for (int k = 0; k < 7; k++)
      push(22'h000400 + 22'(k), blk(22'h000400 + 22'(k)), k[0], "R6");
    // R7/R8: full buffer, round-robin from entry 0
    push(22'h000500, blk(22'h000500), 0, "R7");                   // evicts 100 clean
    push(22'h000501, blk(22'h000501), 0, "R7");                   // evicts 400 clean
    push_wb(22'h000502, 0, 22'h000401, "R8");                     // evicts 401 dirty
    idle();
    look(22'h000100, 2'd0, 0, '0, 0, "R7");
    look(22'h000400, 2'd0, 0, '0, 0, "R7");
    look(22'h000401, 2'd0, 0, '0, 0, "R8");
    look(22'h000500, 2'd0, 1, blk(22'h000500), 0, "R7");
    look(22'h000402, 2'd0, 1, blk(22'h000402), 0, "R3");
    look(22'h000403, 2'd0, 1, blk(22'h000403), 1, "R3");
    push(22'h000600, blk(22'h000600), 1, "R6");                   // freed entry, no wb
    look(22'h000600, 2'd1, 1, blk(22'h000600), 1, "R6");
    idle();
    idle();

    done = 1'b1;
    checks++;
    if (rq.size() != 0 || wq.size() != 0) begin
      fails++;
      $display("FAIL R2 leftover expectations: results=%0d writebacks=%0d expected 0 0",
               rq.size(), wq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule